// File: doc/BRIEF.md
# Serial Infrared Pulse Encoder/Decoder

This block sits between a UART and an off-chip infrared transceiver. On the transmit side it watches the UART serial output on a 16x bit-rate clock enable and turns every zero bit into a short, fixed-length light pulse at the start of a 16-tick bit cell. One bits send no light at all. On the receive side it re-times the active-low infrared receiver line through a synchroniser, throws away pulses narrower than a programmable minimum width, and rebuilds a UART-compatible serial stream. Each accepted pulse becomes a zero bit exactly 16 ticks long.

A 4-bit minimum-width setting gives the acceptance threshold in units of a fixed number of system clocks. A setting of zero turns the filter into a plain falling-edge detector. An internal loopback switch feeds the inverted transmit pulse straight back into the receive path so the whole chain can be tested on chip. A receive-enable bit gates the decoder. With the receiver enabled and loopback off, a UART transmission echoed by the transceiver tests the path outside the chip.

Top module: `irsir_endec`

## Requirements
- R1: While `rst` is high or `cfg_enable` is 0, `ir_txd` is held at 0 and `uart_rxd` at 1, and all phase, width and cell counters are cleared; no input activity changes either output.
- R2: When `uart_txd` is 0 at the first tick of a bit cell, `ir_txd` goes high on that tick and stays high for exactly `PULSE_TICKS` (default 3) tick periods of the 16-tick cell. It rises only on a tick. A falling `uart_txd` while the encoder is in a one cell starts a new cell at that tick.
- R3: A bit cell whose `uart_txd` value is 1 leaves `ir_txd` low for the whole cell.
- R4: The receive line is active-low: `ir_rxd` at 1 is idle and 0 is light. It passes through a `SYNC_STAGES`-flop (default 2) synchroniser that resets to the idle level before any width is measured.
- R5: With `cfg_min_pulse` = N > 0, a low period is accepted only after N x `UNIT_CLKS` (default 4) consecutive low synchronised samples. Shorter low periods produce no output. A period of exactly the threshold is accepted.
- R6: With `cfg_min_pulse` = 0, the first low sample of any low period is accepted, so even a single-clock pulse is taken.
- R7: After a pulse is accepted, `uart_rxd` falls on the next tick and stays low for exactly `CELL_TICKS` (default 16) tick periods. When accepted pulses arrive one cell apart, the low cells join without a gap.
- R8: When `cfg_loop` is 1, the receive path sees the inverse of `ir_txd` and ignores the `ir_rxd` pin. A UART frame sent on `uart_txd` then reappears bit for bit on `uart_rxd`.
- R9: When `cfg_rx_en` is 0, `uart_rxd` stays 1 and the receive counters are cleared, while the transmit encoder keeps working.
- R10: A single low period yields at most one accepted pulse, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud16_en | input | 1 | One-clock enable at 16 times the bit rate |
| cfg_enable | input | 1 | Block enable; 0 forces idle outputs |
| cfg_rx_en | input | 1 | Receive decoder enable |
| cfg_loop | input | 1 | Internal loopback select |
| cfg_min_pulse | input | MINW | Minimum accepted pulse width in units of UNIT_CLKS clocks; 0 selects edge detection |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| uart_rxd | output | 1 | Rebuilt serial data to the UART receiver |
| ir_txd | output | 1 | Pulse drive to the infrared transmitter, active high |
| ir_rxd | input | 1 | Infrared receiver line, active low |

## Verification
If the encoder's cell phase is wrong, `ir_txd` shows a pulse of the wrong length, or one in the wrong cell. Either becomes visible within one 16-tick cell of the first zero bit. If the width counter or the armed flag is wrong, the filter accepts or rejects the wrong pulse. That shows up as a missing or extra low cell on `uart_rxd` about one cell after the boundary-width pulse. If the cell counter is wrong, the low time on `uart_rxd` differs from 16 ticks, or two back-to-back zero bits in a looped-back byte come out split. Either decodes to a wrong byte within one frame.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  typedef struct packed {
    logic enable;
    logic rx_en;
    logic loop;
  } ctl_t;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/irsir_tx_enc.sv
module irsir_tx_enc #(
  parameter int unsigned CELL_TICKS  = 16,
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic txd_i,
  output logic ir_o
);
  localparam int unsigned PW = irsir_pkg::cnt_width(CELL_TICKS - 1);

  logic [PW-1:0] phase;
  logic          cell_one;
  logic          resync;
  logic [PW-1:0] p_eff;

  // a start edge while idling in a one cell re-aligns the cell to this tick
  assign resync = cell_one && !txd_i;
  assign p_eff  = resync ? '0 : phase;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase    <= '0;
      cell_one <= 1'b1;
      ir_o     <= 1'b0;
    end else if (tick) begin
      phase <= (p_eff == PW'(CELL_TICKS - 1)) ? '0 : p_eff + 1'b1;
      if (p_eff == '0) begin
        cell_one <= txd_i;
        ir_o     <= ~txd_i;
      end else if (p_eff < PW'(PULSE_TICKS)) begin
        ir_o <= ~cell_one;
      end else begin
        ir_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irsir_sync.sv
module irsir_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst || clr) chain <= IDLE;
        else            chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst || clr) chain <= {STAGES{IDLE}};
        else            chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/irsir_pulse_filter.sv
module irsir_pulse_filter #(
  parameter int unsigned MINW      = 4,
  parameter int unsigned UNIT_CLKS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [MINW-1:0] min_i,
  input  logic            line_i,
  output logic            acc_o
);
  localparam int unsigned MAXTHR = ((1 << MINW) - 1) * UNIT_CLKS;
  localparam int unsigned CW     = irsir_pkg::cnt_width(MAXTHR);

  logic [CW-1:0] run;
  logic [CW-1:0] run_nxt;
  logic [CW-1:0] thr;
  logic          armed;
  logic          edge_mode;
  logic          hit;

  assign thr       = CW'(min_i) * CW'(UNIT_CLKS);
  assign run_nxt   = run + 1'b1;
  assign edge_mode = (min_i == '0);
  assign hit       = edge_mode || (run_nxt >= thr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run   <= '0;
      armed <= 1'b1;
      acc_o <= 1'b0;
    end else begin
      acc_o <= 1'b0;
      if (line_i) begin
        run   <= '0;
        armed <= 1'b1;
      end else if (armed) begin
        if (hit) begin
          acc_o <= 1'b1;
          armed <= 1'b0;
          run   <= '0;
        end else begin
          run <= run_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/irsir_rx_regen.sv
module irsir_rx_regen #(
  parameter int unsigned CELL_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic acc_i,
  output logic rxd_o
);
  localparam int unsigned RW = irsir_pkg::cnt_width(CELL_TICKS - 1);

  logic [RW-1:0] left;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend  <= 1'b0;
      left  <= '0;
      rxd_o <= 1'b1;
    end else begin
      pend <= acc_i | (pend & ~tick);
      if (tick) begin
        if (pend) begin
          rxd_o <= 1'b0;
          left  <= RW'(CELL_TICKS - 1);
        end else if (!rxd_o) begin
          if (left == '0) rxd_o <= 1'b1;
          else            left  <= left - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irsir_endec.sv
module irsir_endec
  import irsir_pkg::*;
#(
  parameter int unsigned CELL_TICKS  = 16,
  parameter int unsigned PULSE_TICKS = 3,
  parameter int unsigned MINW        = 4,
  parameter int unsigned UNIT_CLKS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            baud16_en,
  input  logic            cfg_enable,
  input  logic            cfg_rx_en,
  input  logic            cfg_loop,
  input  logic [MINW-1:0] cfg_min_pulse,
  input  logic            uart_txd,
  output logic            uart_rxd,
  output logic            ir_txd,
  input  logic            ir_rxd
);
  ctl_t ctl;
  logic tx_clr;
  logic rx_clr;
  logic tx_pulse;
  logic rx_line;
  logic rx_sync;
  logic accepted;

  assign ctl    = '{enable: cfg_enable, rx_en: cfg_rx_en, loop: cfg_loop};
  assign tx_clr = !ctl.enable;
  assign rx_clr = !ctl.enable || !ctl.rx_en;

  irsir_tx_enc #(
    .CELL_TICKS (CELL_TICKS),
    .PULSE_TICKS(PULSE_TICKS)
  ) u_tx (
    .clk  (clk),
    .rst  (rst),
    .clr  (tx_clr),
    .tick (baud16_en),
    .txd_i(uart_txd),
    .ir_o (tx_pulse)
  );

  assign ir_txd  = tx_pulse;
  assign rx_line = ctl.loop ? ~tx_pulse : ir_rxd;

  irsir_sync #(
    .STAGES(SYNC_STAGES),
    .IDLE  (1'b1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .clr(rx_clr),
    .d_i(rx_line),
    .q_o(rx_sync)
  );

  irsir_pulse_filter #(
    .MINW     (MINW),
    .UNIT_CLKS(UNIT_CLKS)
  ) u_filt (
    .clk   (clk),
    .rst   (rst),
    .clr   (rx_clr),
    .min_i (cfg_min_pulse),
    .line_i(rx_sync),
    .acc_o (accepted)
  );

  irsir_rx_regen #(
    .CELL_TICKS(CELL_TICKS)
  ) u_regen (
    .clk  (clk),
    .rst  (rst),
    .clr  (rx_clr),
    .tick (baud16_en),
    .acc_i(accepted),
    .rxd_o(uart_rxd)
  );

endmodule

// File: rtl/irsir_endec_chk.sv
module irsir_endec_chk #(
  parameter int unsigned PULSE_TICKS = 3
) (
  input logic clk,
  input logic rst,
  input logic baud16_en,
  input logic cfg_enable,
  input logic cfg_rx_en,
  input logic uart_txd,
  input logic uart_rxd,
  input logic ir_txd
);
  logic [7:0] hi_ticks;

  always_ff @(posedge clk) begin
    if (rst || !ir_txd)  hi_ticks <= '0;
    else if (baud16_en)  hi_ticks <= hi_ticks + 1'b1;
  end

  AST_OFF_TX_LOW: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !ir_txd); // R1

  AST_OFF_RX_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable || !cfg_rx_en) |=> uart_rxd); // R9

  AST_TX_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_txd) |-> ($past(baud16_en) && !$past(uart_txd))); // R2

  AST_TX_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    ir_txd |-> (hi_ticks < 8'(PULSE_TICKS))); // R2

  AST_RXD_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(uart_rxd) |-> $past(baud16_en)); // R7

endmodule

bind irsir_endec irsir_endec_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .baud16_en (baud16_en),
  .cfg_enable(cfg_enable),
  .cfg_rx_en (cfg_rx_en),
  .uart_txd  (uart_txd),
  .uart_rxd  (uart_rxd),
  .ir_txd    (ir_txd)
);

// File: tb/test_irsir_endec.sv
`timescale 1ns/1ps
module test_irsir_endec;
  localparam int TICK_DIV = 8;
  localparam int CELL_CYC = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud16_en = 1'b0;
  logic       cfg_enable = 1'b0;
  logic       cfg_rx_en = 1'b0;
  logic       cfg_loop = 1'b0;
  logic [3:0] cfg_min_pulse = 4'd0;
  logic       uart_txd = 1'b1;
  logic       uart_rxd;
  logic       ir_txd;
  logic       ir_rxd = 1'b1;

  int vectors = 0;
  int fails   = 0;
  int tdiv    = 0;

  int ir_hi_cyc, ir_rises, rx_lo_cyc, rx_falls;
  logic ir_prev = 1'b0, rx_prev = 1'b1;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud16_en <= (tdiv == 0);
  end

  always @(posedge clk) begin
    #2;
    if (ir_txd) ir_hi_cyc++;
    if (ir_txd && !ir_prev) ir_rises++;
    if (!uart_rxd) rx_lo_cyc++;
    if (!uart_rxd && rx_prev) rx_falls++;
    ir_prev = ir_txd;
    rx_prev = uart_rxd;
  end

  irsir_endec i_irsir_endec (
    .clk          (clk),
    .rst          (rst),
    .baud16_en    (baud16_en),
    .cfg_enable   (cfg_enable),
    .cfg_rx_en    (cfg_rx_en),
    .cfg_loop     (cfg_loop),
    .cfg_min_pulse(cfg_min_pulse),
    .uart_txd     (uart_txd),
    .uart_rxd     (uart_rxd),
    .ir_txd       (ir_txd),
    .ir_rxd       (ir_rxd)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    ir_hi_cyc = 0; ir_rises = 0; rx_lo_cyc = 0; rx_falls = 0;
  endtask

  task automatic align_tick();
    do begin
      @(negedge clk);
      #1;
    end while (!baud16_en);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    align_tick();
    for (int i = 0; i < n; i++) begin
      uart_txd = bits[i];
      repeat (CELL_CYC) @(negedge clk);
    end
    uart_txd = 1'b1;
  endtask

  task automatic ir_pulse(input int width);
    @(negedge clk);
    ir_rxd = 1'b0;
    repeat (width) @(negedge clk);
    ir_rxd = 1'b1;
    repeat (3 * CELL_CYC) @(negedge clk);
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    check("R1 reset ir_txd", int'(ir_txd), 0);
    check("R1 reset uart_rxd", int'(uart_rxd), 1);
  endtask

  task automatic t_tx_zero();
    cfg_enable = 1'b1; cfg_rx_en = 1'b0; cfg_loop = 1'b0;
    clr_mon();
    send_bits(16'b110, 3);
    check("R2 pulse cycles", ir_hi_cyc, 3 * TICK_DIV);
    check("R2 pulse count", ir_rises, 1);
    check("R9 rx disabled no output", rx_lo_cyc, 0);
  endtask

  task automatic t_tx_ones();
    clr_mon();
    send_bits(16'b1111, 4);
    check("R3 one cells silent", ir_hi_cyc, 0);
  endtask

  task automatic t_loop_byte();
    logic [9:0] frame;
    logic [9:0] got;
    frame = {1'b1, 8'hA5, 1'b0};
    got   = '0;
    cfg_loop = 1'b1; cfg_rx_en = 1'b1; cfg_min_pulse = 4'd2;
    repeat (4) @(negedge clk);
    clr_mon();
    fork
      send_bits({6'h3F, frame}, 12);
      begin
        int guard = 0;
        do begin
          @(posedge clk); #2;
          guard++;
        end while (uart_rxd && guard < 4000);
        repeat (CELL_CYC / 2) @(posedge clk);
        for (int k = 0; k < 10; k++) begin
          #2 got[k] = uart_rxd;
          if (k < 9) repeat (CELL_CYC) @(posedge clk);
        end
      end
    join
    repeat (2 * CELL_CYC) @(negedge clk);
    check("R8 loopback byte", int'(got[8:1]), 8'hA5);
    check("R8 loopback stop bit", int'(got[9]), 1);
    check("R2 loopback pulses", ir_rises, 5);
    check("R2 loopback pulse cycles", ir_hi_cyc, 5 * 3 * TICK_DIV);
    check("R7 joined cells", rx_falls, 4);
    check("R7 low cycles", rx_lo_cyc, 5 * CELL_CYC);
  endtask

  task automatic t_filter();
    cfg_loop = 1'b0; cfg_rx_en = 1'b1;
    cfg_min_pulse = 4'd15;
    clr_mon(); ir_pulse(40);
    check("R5 narrow rejected", rx_lo_cyc, 0);
    clr_mon(); ir_pulse(70);
    check("R5 wide accepted", rx_lo_cyc, CELL_CYC);
    check("R4 active-low sense", rx_falls, 1);
    cfg_min_pulse = 4'd1;
    clr_mon(); ir_pulse(3);
    check("R5 below threshold", rx_lo_cyc, 0);
    clr_mon(); ir_pulse(4);
    check("R5 at threshold", rx_lo_cyc, CELL_CYC);
  endtask

  task automatic t_edge_mode();
    cfg_min_pulse = 4'd0;
    clr_mon(); ir_pulse(1);
    check("R6 single clock accepted", rx_lo_cyc, CELL_CYC);
    clr_mon(); ir_pulse(300);
    check("R10 long low one cell", rx_falls, 1);
    check("R10 long low cycles", rx_lo_cyc, CELL_CYC);
  endtask

  task automatic t_loop_ignores_pin();
    cfg_loop = 1'b1;
    clr_mon(); ir_pulse(70);
    check("R8 pin ignored in loopback", rx_lo_cyc, 0);
    cfg_loop = 1'b0;
  endtask

  task automatic t_rx_disabled();
    cfg_rx_en = 1'b0;
    clr_mon(); ir_pulse(70);
    check("R9 rx disabled", rx_lo_cyc, 0);
    clr_mon();
    send_bits(16'b10, 2);
    check("R9 tx still works", ir_rises, 1);
  endtask

  task automatic t_disabled();
    cfg_enable = 1'b0; cfg_rx_en = 1'b1;
    clr_mon();
    send_bits(16'b10, 2);
    ir_pulse(70);
    check("R1 disabled tx silent", ir_hi_cyc, 0);
    check("R1 disabled rx idle", rx_lo_cyc, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_zero();
    t_tx_ones();
    t_loop_byte();
    t_filter();
    t_edge_mode();
    t_loop_ignores_pin();
    t_rx_disabled();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule